// File: doc/BRIEF.md
# Dual-Lane Delayed Sample Renderer

This block renders the output signal of one loudspeaker from a block of filtered audio held in a sample buffer. A virtual source sits at some distance from the speaker, and that distance may change by a fixed amount from one sample to the next as the source moves. For every output sample the block advances the distance and turns it into a propagation delay counted in samples. It then reads the filtered sample that lies that many positions back and scales it by the speaker's amplitude decay and by a master volume.

Two selection lanes run side by side, so two output samples come out per clock. Lane 0 produces the even sample positions and lane 1 the odd ones. A packer groups four 16-bit results into one 64-bit word and writes it to an output memory port. Software loads the per-speaker parameters on the input pins and pulses `start`. The block latches the parameters and runs one full buffer. It signals `done` with the last write.

Top module: `dual_lane_delay_render`

## Requirements
- R1: Output sample s (0 to N_SMP-1) uses the distance d(s) = dist_init + (s+1)*dist_step. Distances are signed fixed point with 17 fraction bits. Lane 0 starts its accumulator one step past dist_init and lane 1 starts it two steps past. Each lane adds two steps per cycle.
- R2: The read position is idx(s) = s - (latency + round(dist_factor * d(s))). dist_factor is unsigned with 8 fraction bits. The rounding adds one half and then floors.
- R3: When idx(s) is below 0 or above N_SMP-1, the buffer value is replaced by zero.
- R4: Each result is floor((x*amp_decay*master_vol + 2^29) / 2^30), saturated to the range -32768..32767. Here x is the selected sample, and both gains are unsigned with 15 fraction bits, so 0x8000 means 1.0.
- R5: Two results are produced per cycle. After the pipeline fills, write strobes appear exactly every second cycle and never on two consecutive cycles.
- R6: Word w holds samples 4w, 4w+1, 4w+2 and 4w+3 in bits [15:0], [31:16], [47:32] and [63:48]. Word addresses start at 0 and rise by one per write, N_SMP/4 writes in total.
- R7: `done` is a one-cycle pulse that coincides with the write to the last word address. `busy` falls on the next cycle. At most 523 cycles pass from the accepting edge to `done`.
- R8: The parameters are latched on the edge that accepts `start`. A `start` while `busy`, and any change of the parameter inputs during a run, have no effect on the results.
- R9: After synchronous reset, `busy`, `done` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one rendering run (ignored while busy) |
| dist_init | input | 22 | Signed source distance before sample 0, 17 fraction bits |
| dist_step | input | 22 | Signed per-sample distance increment, 17 fraction bits |
| amp_decay | input | 16 | Unsigned amplitude decay, 15 fraction bits |
| master_vol | input | 16 | Unsigned master volume, 15 fraction bits |
| dist_factor | input | 16 | Unsigned samples-per-distance factor, 8 fraction bits |
| latency | input | 16 | Fixed extra delay in samples |
| rd_addr0 | output | 10 | Buffer read address, lane 0 |
| rd_data0 | input | 16 | Buffer data for lane 0, one cycle after address |
| rd_addr1 | output | 10 | Buffer read address, lane 1 |
| rd_data1 | input | 16 | Buffer data for lane 1, one cycle after address |
| wr_en | output | 1 | Output word write strobe |
| wr_addr | output | 8 | Output word address |
| wr_data | output | 64 | Four packed 16-bit results |
| busy | output | 1 | Run in progress |
| done | output | 1 | Final word is being written |

## Verification
The assertions check the write cadence on every cycle: no two adjacent strobes, word addresses rising by one, and the packer always emptied after a write. They also check that `done` is followed by `busy` falling, that a run stays inside the cycle budget, and that the latched parameters hold still through a run. Only the bench's scenarios can show that the delay arithmetic is right. That covers rounding of the delay, the zero fill at both ends of the buffer, saturation of the scaled product, approaching and receding sources, and a second `start` with altered inputs in mid-run leaving the output unchanged.

// File: rtl/dlr_pkg.sv
package dlr_pkg;
    localparam int SMP_W     = 16;
    localparam int DIST_W    = 22;
    localparam int DIST_FRAC = 17;
    localparam int DF_W      = 16;
    localparam int DF_FRAC   = 8;
    localparam int GAIN_W    = 16;
    localparam int GAIN_FRAC = 15;
    localparam int LAT_W     = 16;
    localparam int POS_W     = 16;
    localparam int DLY_SH    = DIST_FRAC + DF_FRAC;
    localparam int SCL_SH    = 2 * GAIN_FRAC;

    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic signed [DIST_W-1:0] dist_t;
    typedef logic signed [47:0]       wide_t;
    typedef logic signed [49:0]       prod_t;

    typedef struct packed {
        dist_t             step;
        logic [GAIN_W-1:0] amp;
        logic [GAIN_W-1:0] vol;
        logic [DF_W-1:0]   df;
        logic [LAT_W-1:0]  lat;
    } spk_par_t;

    // Signed buffer position of the sample that output position s selects.
    function automatic wide_t read_pos(input logic [POS_W-1:0] s, input dist_t d,
                                       input logic [DF_W-1:0] df, input logic [LAT_W-1:0] lat);
        wide_t p;
        p = wide_t'(signed'({1'b0, df})) * wide_t'(d);
        p = p + (wide_t'(1) <<< (DLY_SH - 1));
        p = p >>> DLY_SH;
        return wide_t'(signed'({1'b0, s})) - wide_t'(signed'({1'b0, lat})) - p;
    endfunction

    // Apply both unsigned gains, round to nearest (half up) and saturate.
    function automatic smp_t apply_gain(input smp_t x, input logic [GAIN_W-1:0] a,
                                        input logic [GAIN_W-1:0] v);
        prod_t p;
        p = prod_t'(x) * prod_t'(signed'({1'b0, a})) * prod_t'(signed'({1'b0, v}));
        p = (p + (prod_t'(1) <<< (SCL_SH - 1))) >>> SCL_SH;
        if (p > prod_t'(32767))       return smp_t'(16'sh7FFF);
        else if (p < prod_t'(-32768)) return smp_t'(16'sh8000);
        else                          return smp_t'(p);
    endfunction
endpackage

// File: rtl/dlr_lane.sv
module dlr_lane
    import dlr_pkg::*;
#(
    parameter int N_SMP = 1024,
    parameter int LANE  = 0,
    localparam int ADDR_W = $clog2(N_SMP),
    localparam int PAIR_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  dist_t             acc_init,
    input  dist_t             stride,
    input  logic [PAIR_W-1:0] pair,
    input  logic [DF_W-1:0]   df,
    input  logic [LAT_W-1:0]  lat,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              hit,
    output logic              vld
);
    dist_t             acc;
    logic [ADDR_W-1:0] pos;
    wide_t             idx;

    assign pos = {pair, 1'(LANE)};
    assign idx = read_pos(POS_W'(pos), acc, df, lat);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            rd_addr <= '0;
            hit     <= 1'b0;
            vld     <= 1'b0;
        end else begin
            vld <= adv;
            if (load) begin
                acc <= acc_init;
            end else if (adv) begin
                acc     <= acc + stride;
                rd_addr <= idx[ADDR_W-1:0];
                hit     <= (idx >= wide_t'(0)) && (idx < wide_t'(N_SMP));
            end
        end
    end
endmodule

// File: rtl/dlr_scale.sv
module dlr_scale
    import dlr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_i,
    input  logic              hit_i,
    input  smp_t              data_i,
    input  logic [GAIN_W-1:0] amp,
    input  logic [GAIN_W-1:0] vol,
    output smp_t              res_o,
    output logic              vld_o
);
    smp_t sel;
    assign sel = hit_i ? data_i : smp_t'(0);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o <= '0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) res_o <= apply_gain(sel, amp, vol);
        end
    end
endmodule

// File: rtl/dlr_pack.sv
module dlr_pack
    import dlr_pkg::*;
#(
    parameter int WORD_AW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               vld,
    input  smp_t               res0,
    input  smp_t               res1,
    output logic               wr_en,
    output logic [WORD_AW-1:0] wr_addr,
    output logic [63:0]        wr_data,
    output logic               last
);
    logic               half;
    logic [31:0]        held;
    logic [WORD_AW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            half    <= 1'b0;
            held    <= '0;
            cnt     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            last    <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            last  <= 1'b0;
            if (clr) begin
                half <= 1'b0;
                cnt  <= '0;
            end else if (vld) begin
                if (!half) begin
                    held <= {res1, res0};
                    half <= 1'b1;
                end else begin
                    wr_en   <= 1'b1;
                    wr_addr <= cnt;
                    wr_data <= {res1, res0, held};
                    last    <= (cnt == {WORD_AW{1'b1}});
                    cnt     <= cnt + 1'b1;
                    half    <= 1'b0;
                end
            end
        end
    end

    // R6: every write empties the half-word holder
    a_r6_pack_drained: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !half);
endmodule

// File: rtl/dual_lane_delay_render.sv
module dual_lane_delay_render
    import dlr_pkg::*;
#(
    parameter int N_SMP      = 1024,
    parameter int CYC_BUDGET = 523,
    localparam int ADDR_W  = $clog2(N_SMP),
    localparam int PAIR_W  = ADDR_W - 1,
    localparam int WORD_AW = ADDR_W - 2,
    localparam int LANES   = 2,
    localparam int BCNT_W  = $clog2(CYC_BUDGET + 1) + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic signed [DIST_W-1:0]   dist_init,
    input  logic signed [DIST_W-1:0]   dist_step,
    input  logic [GAIN_W-1:0]          amp_decay,
    input  logic [GAIN_W-1:0]          master_vol,
    input  logic [DF_W-1:0]            dist_factor,
    input  logic [LAT_W-1:0]           latency,
    output logic [ADDR_W-1:0]          rd_addr0,
    input  logic signed [SMP_W-1:0]    rd_data0,
    output logic [ADDR_W-1:0]          rd_addr1,
    input  logic signed [SMP_W-1:0]    rd_data1,
    output logic                       wr_en,
    output logic [WORD_AW-1:0]         wr_addr,
    output logic [63:0]                wr_data,
    output logic                       busy,
    output logic                       done
);
    localparam logic [PAIR_W-1:0] PAIR_LAST = '1;

    spk_par_t          par;
    logic              issuing;
    logic [PAIR_W-1:0] pair;
    logic              accept;
    logic              pk_last;

    logic [ADDR_W-1:0] l_addr [LANES];
    logic              l_hit  [LANES];
    logic              l_vld  [LANES];
    logic              s2_hit [LANES];
    logic              s2_vld [LANES];
    smp_t              s2_dat [LANES];
    smp_t              s3_res [LANES];
    logic              s3_vld [LANES];

    assign accept   = start && !busy;
    assign rd_addr0 = l_addr[0];
    assign rd_addr1 = l_addr[1];
    assign s2_dat[0] = rd_data0;
    assign s2_dat[1] = rd_data1;
    assign done     = wr_en && pk_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            par     <= '0;
            issuing <= 1'b0;
            pair    <= '0;
            busy    <= 1'b0;
        end else if (accept) begin
            par     <= '{step: dist_step, amp: amp_decay, vol: master_vol,
                         df: dist_factor, lat: latency};
            issuing <= 1'b1;
            pair    <= '0;
            busy    <= 1'b1;
        end else begin
            if (issuing) begin
                pair <= pair + 1'b1;
                if (pair == PAIR_LAST) issuing <= 1'b0;
            end
            if (done) busy <= 1'b0;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dist_t l_init;
        assign l_init = dist_init + (dist_step <<< g);

        dlr_lane #(.N_SMP(N_SMP), .LANE(g)) u_lane (
            .clk(clk), .rst(rst), .load(accept), .adv(issuing),
            .acc_init(l_init), .stride(par.step <<< 1), .pair(pair),
            .df(par.df), .lat(par.lat),
            .rd_addr(l_addr[g]), .hit(l_hit[g]), .vld(l_vld[g])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                s2_hit[g] <= 1'b0;
                s2_vld[g] <= 1'b0;
            end else begin
                s2_hit[g] <= l_hit[g];
                s2_vld[g] <= l_vld[g];
            end
        end

        dlr_scale u_scale (
            .clk(clk), .rst(rst), .vld_i(s2_vld[g]), .hit_i(s2_hit[g]),
            .data_i(s2_dat[g]), .amp(par.amp), .vol(par.vol),
            .res_o(s3_res[g]), .vld_o(s3_vld[g])
        );
    end

    dlr_pack #(.WORD_AW(WORD_AW)) u_pack (
        .clk(clk), .rst(rst), .clr(accept), .vld(s3_vld[0]),
        .res0(s3_res[0]), .res1(s3_res[1]),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .last(pk_last)
    );

    // ---------------- checks ----------------
    logic [WORD_AW-1:0] last_wa;
    logic [BCNT_W-1:0]  busy_cyc;
    always_ff @(posedge clk) begin
        if (rst) begin
            last_wa  <= '0;
            busy_cyc <= '0;
        end else begin
            if (wr_en) last_wa <= wr_addr;
            busy_cyc <= busy ? busy_cyc + 1'b1 : '0;
        end
    end

    // R5: write strobes never on adjacent cycles
    a_r5_write_spacing: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);
    // R6: word addresses rise by one
    a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0) |-> (wr_addr == last_wa + 1'b1));
    // R7: busy released right after done
    a_r7_done_release: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    // R7: run completes within budget
    a_r7_cycle_budget: assert property (@(posedge clk) disable iff (rst)
        busy_cyc <= BCNT_W'(CYC_BUDGET));
    // R8: latched parameters hold during a run
    a_r8_params_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(rst)) |-> $stable(par));
endmodule

// File: tb/dual_lane_delay_render_tb.sv
module dual_lane_delay_render_tb;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic signed [21:0] dist_init = '0;
    logic signed [21:0] dist_step = '0;
    logic [15:0]        amp_decay = '0;
    logic [15:0]        master_vol = '0;
    logic [15:0]        dist_factor = '0;
    logic [15:0]        latency = '0;
    logic [9:0]         rd_addr0, rd_addr1;
    logic signed [15:0] rd_data0 = '0, rd_data1 = '0;
    logic               wr_en, busy, done;
    logic [7:0]         wr_addr;
    logic [63:0]        wr_data;

    always #4 clk = ~clk;

    dual_lane_delay_render u_dut (
        .clk(clk), .rst(rst), .start(start), .dist_init(dist_init), .dist_step(dist_step),
        .amp_decay(amp_decay), .master_vol(master_vol), .dist_factor(dist_factor),
        .latency(latency), .rd_addr0(rd_addr0), .rd_data0(rd_data0),
        .rd_addr1(rd_addr1), .rd_data1(rd_data1), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .done(done)
    );

    logic signed [15:0] mem [1024];
    always @(posedge clk) begin
        rd_data0 <= mem[rd_addr0];
        rd_data1 <= mem[rd_addr1];
    end

    int n_chk = 0, n_bad = 0;
    longint tcyc = 0;
    always @(posedge clk) tcyc++;

    logic [63:0] got [256];
    int     n_wr = 0, gap_bad = 0;
    longint last_wr = -1;
    always @(negedge clk) begin
        if (wr_en) begin
            got[wr_addr] = wr_data;
            if (last_wr >= 0 && tcyc - last_wr != 2) gap_bad++;
            last_wr = tcyc;
            n_wr++;
        end
    end

    longint e_d0, e_step, e_amp, e_vol, e_df, e_lat;

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void fill(input int pat);
        for (int i = 0; i < 1024; i++) begin
            if (pat == 0) mem[i] = 16'((((i * 173) % 4001) - 2000) * 8);
            else case (i % 4)
                0: mem[i] = 16'sh7FFF;
                1: mem[i] = 16'sh8000;
                2: mem[i] = 16'sd5;
                default: mem[i] = -16'sd3;
            endcase
        end
    endfunction

    function automatic longint exp_smp(input int s);
        longint d, r, idx, x, g;
        d   = e_d0 + longint'(s + 1) * e_step;
        r   = (e_df * d + (64'sd1 <<< 24)) >>> 25;
        idx = longint'(s) - e_lat - r;
        x   = (idx >= 0 && idx < 1024) ? longint'(mem[idx]) : 0;
        g   = (x * e_amp * e_vol + (64'sd1 <<< 29)) >>> 30;
        if (g > 32767) g = 32767;
        if (g < -32768) g = -32768;
        return g;
    endfunction

    function automatic logic [63:0] exp_word(input int w);
        logic [63:0] v;
        for (int k = 0; k < 4; k++) v[16*k +: 16] = 16'(exp_smp(4 * w + k));
        return v;
    endfunction

    task automatic launch(input longint d0, st, amp, vol, df, lat);
        @(negedge clk);
        dist_init = 22'(d0); dist_step = 22'(st); amp_decay = 16'(amp);
        master_vol = 16'(vol); dist_factor = 16'(df); latency = 16'(lat);
        e_d0 = d0; e_step = st; e_amp = amp; e_vol = vol; e_df = df; e_lat = lat;
        n_wr = 0; gap_bad = 0; last_wr = -1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run(input string req);
        int  cyc = 1;
        logic addr_ok = 1'b0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        if (done) addr_ok = (wr_addr == 8'd255);
        check("R7 done within budget", (done && cyc <= 523) ? 1 : 0, 1);
        check("R7 done with last word", addr_ok, 1);
        @(negedge clk);
        check("R7 busy falls after done", busy, 0);
        check("R6 write count", n_wr, 256);
        check("R5 two-cycle write spacing", gap_bad, 0);
        for (int w = 0; w < 256; w++) check(req, got[w], exp_word(w));
    endtask

    task automatic t_reset;
        check("R9 busy after reset", busy, 0);
        check("R9 done after reset", done, 0);
        check("R9 wr_en after reset", wr_en, 0);
    endtask

    task automatic t_still;   // R1 R2 R3 R4 R6: fixed source, 290-sample delay
        fill(0);
        launch(2 <<< 17, 0, 16'h4000, 16'h8000, 140 <<< 8, 10);
        finish_run("R2 still source");
    endtask

    task automatic t_moving;  // R1 receding source, fractional factor
        fill(0);
        launch((3 <<< 17) / 2, 26, 16'h6000, 16'h7000, 35174, 3);
        finish_run("R1 receding source");
    endtask

    task automatic t_approach; // R1 approaching source
        fill(0);
        launch(3 <<< 17, -40, 16'h8000, 16'h8000, 35174, 0);
        finish_run("R1 approaching source");
    endtask

    task automatic t_range;   // R3 both ends
        fill(0);
        launch(0, 0, 16'h8000, 16'h8000, 35840, 1100);
        finish_run("R3 all below zero");
        launch(-(1 <<< 17), 0, 16'h8000, 16'h8000, 35840, 0);
        finish_run("R3 above top");
    endtask

    task automatic t_sat;     // R4 saturation and rounding
        fill(1);
        launch(1 <<< 16, 7, 16'hFFFF, 16'hFFFF, 35840, 2);
        finish_run("R4 saturate");
        launch(1 <<< 16, 7, 16'h3000, 16'h2000, 35840, 2);
        finish_run("R4 round small");
    endtask

    task automatic t_busy;    // R8 restart and input change ignored mid-run
        fill(0);
        launch(2 <<< 17, 13, 16'h5000, 16'h7FFF, 35174, 5);
        repeat (100) @(negedge clk);
        dist_init = 22'sd9999; dist_step = -22'sd500; amp_decay = 16'h0100;
        master_vol = 16'h0200; dist_factor = 16'd100; latency = 16'd700;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_run("R8 start while busy ignored");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_still();
        t_moving();
        t_approach();
        t_range();
        t_sat();
        t_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule